// File: doc/BRIEF.md
# Associative Translation Lookup With Multiple-Match Detection

This block is the lookup stage of a fully associative unified translation buffer for 4 KB pages. It holds a parameterised set of entries, each with a valid flag, a virtual page number and a physical page number. It compares a requested virtual page number against every valid entry in parallel. The result is one of three outcomes: a single hit, which returns the physical page number; a miss; or a multiple match. A multiple match is a fatal outcome in its own right, and the physical page number is withheld because it cannot be trusted.

Requests come from two places. The load/store path sends data lookups tagged with an access-kind code. The hardware walker that refills the instruction-side buffer sends its own lookups. When both ask in the same cycle, the data path wins. The request is registered, the compare runs in the following cycle, and the result is registered with a one-cycle valid strobe. Entries are written through a single write port that takes effect at the next clock edge.

Top module: `utlb_lookup`

## Requirements
- R1: After reset, `rsp_valid_o` is 0 and every entry is invalid, so any lookup, including one for page number 0, reports a miss.
- R2: When exactly one valid entry matches, the response has status 2'b01, `rsp_ppn_o` equal to that entry's physical page number, and `rsp_ppn_ok_o` = 1.
- R3: When no valid entry matches, the response has status 2'b00, `rsp_ppn_o` = 0 and `rsp_ppn_ok_o` = 0.
- R4: When two or more valid entries match, the response has status 2'b10, `rsp_ppn_o` = 0 and `rsp_ppn_ok_o` = 0.
- R5: Instruction-refill lookups produce the same three outcomes, including multiple match, and their response carries `rsp_src_o` = 1. Data responses carry `rsp_src_o` = 0.
- R6: For a data lookup, `rsp_write_o` is 1 for kind codes 1 (store), 4 (block invalidate) and 5 (block allocate-store). It is 0 for codes 0 (load), 2 (block purge), 3 (block write-back), 6 and 7. Instruction-refill responses always have `rsp_write_o` = 0.
- R7: When `d_req_i` and `i_req_i` are both high in the same cycle, `i_gnt_o` is 0 and the data request is served. `i_gnt_o` is 1 when `i_req_i` is high and `d_req_i` is low.
- R8: A request accepted at clock edge k produces a one-cycle `rsp_valid_o` pulse after edge k+1. No response appears without an accepted request.
- R9: An entry write takes effect at the next clock edge. A lookup whose compare cycle coincides with that write sees the old contents.
- R10: An entry written with `wr_valid_i` = 0 never matches, whatever its stored page number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| d_req_i | input | 1 | Data lookup request |
| d_vpn_i | input | 22 | Data virtual page number |
| d_kind_i | input | 3 | Data access-kind code |
| i_req_i | input | 1 | Instruction-refill lookup request |
| i_vpn_i | input | 22 | Instruction-refill virtual page number |
| i_gnt_o | output | 1 | Instruction-refill request accepted this cycle |
| wr_en_i | input | 1 | Entry write enable |
| wr_idx_i | input | 6 | Entry index to write |
| wr_valid_i | input | 1 | Valid flag to store |
| wr_vpn_i | input | 22 | Virtual page number to store |
| wr_ppn_i | input | 19 | Physical page number to store |
| rsp_valid_o | output | 1 | Response strobe |
| rsp_src_o | output | 1 | 0 data, 1 instruction refill |
| rsp_status_o | output | 2 | 00 miss, 01 hit, 10 multiple match |
| rsp_write_o | output | 1 | Access classified as a write |
| rsp_ppn_o | output | 19 | Physical page number, 0 unless a single hit |
| rsp_ppn_ok_o | output | 1 | Physical page number is trustworthy |

## Verification
A multiple match is the hardest outcome to reach. The bench fills the table with page numbers made unique by their index bits, so random traffic alone almost never produces a duplicate. The stimulus therefore creates duplicates on purpose: directed writes copy one entry's page number into a second entry, and random rewrites sometimes copy another entry's page number. It then looks those pages up from both the data and the instruction-refill source. A second hard case is a write that lands exactly in a lookup's compare cycle. A directed sequence asserts the write on the cycle after the request is accepted, and a follow-up lookup confirms the new contents.

// File: rtl/utlb_pkg.sv
package utlb_pkg;
  typedef enum logic [1:0] {
    ST_MISS  = 2'b00,
    ST_HIT   = 2'b01,
    ST_MULTI = 2'b10
  } status_e;

  // store, block invalidate, block allocate-store are writes
  function automatic logic kind_is_write(input logic [2:0] kind);
    return (kind == 3'd1) || (kind == 3'd4) || (kind == 3'd5);
  endfunction
endpackage

// File: rtl/utlb_req_arb.sv
module utlb_req_arb #(
  parameter int VPN_W = 22
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             d_req_i,
  input  logic [VPN_W-1:0] d_vpn_i,
  input  logic [2:0]       d_kind_i,
  input  logic             i_req_i,
  input  logic [VPN_W-1:0] i_vpn_i,
  output logic             i_gnt_o,
  output logic             q_valid_o,
  output logic             q_src_o,
  output logic             q_write_o,
  output logic [VPN_W-1:0] q_vpn_o
);
  import utlb_pkg::*;

  assign i_gnt_o = i_req_i & ~d_req_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_valid_o <= 1'b0;
      q_src_o   <= 1'b0;
      q_write_o <= 1'b0;
      q_vpn_o   <= '0;
    end else begin
      q_valid_o <= d_req_i | i_req_i;
      if (d_req_i) begin
        q_src_o   <= 1'b0;
        q_write_o <= kind_is_write(d_kind_i);
        q_vpn_o   <= d_vpn_i;
      end else if (i_req_i) begin
        q_src_o   <= 1'b1;
        q_write_o <= 1'b0;
        q_vpn_o   <= i_vpn_i;
      end
    end
  end
endmodule

// File: rtl/utlb_entry_array.sv
module utlb_entry_array #(
  parameter int N_ENTRIES = 64,
  parameter int VPN_W     = 22,
  parameter int PPN_W     = 19,
  localparam int IDX_W    = $clog2(N_ENTRIES)
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            wr_en_i,
  input  logic [IDX_W-1:0]                wr_idx_i,
  input  logic                            wr_valid_i,
  input  logic [VPN_W-1:0]                wr_vpn_i,
  input  logic [PPN_W-1:0]                wr_ppn_i,
  input  logic [VPN_W-1:0]                look_vpn_i,
  output logic [N_ENTRIES-1:0]            match_o,
  output logic [N_ENTRIES-1:0][PPN_W-1:0] ppn_tbl_o
);
  for (genvar e = 0; e < N_ENTRIES; e++) begin : g_ent
    logic             vld_q;
    logic [VPN_W-1:0] vpn_q;
    logic [PPN_W-1:0] ppn_q;
    logic             sel;

    assign sel = wr_en_i && (wr_idx_i == IDX_W'(e));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q <= 1'b0;
        vpn_q <= '0;
        ppn_q <= '0;
      end else if (sel) begin
        vld_q <= wr_valid_i;
        vpn_q <= wr_vpn_i;
        ppn_q <= wr_ppn_i;
      end
    end

    assign match_o[e]   = vld_q && (vpn_q == look_vpn_i);
    assign ppn_tbl_o[e] = ppn_q;
  end
endmodule

// File: rtl/utlb_hit_resolve.sv
module utlb_hit_resolve #(
  parameter int N_ENTRIES = 64,
  parameter int PPN_W     = 19
) (
  input  logic [N_ENTRIES-1:0]            match_i,
  input  logic [N_ENTRIES-1:0][PPN_W-1:0] ppn_tbl_i,
  output logic [1:0]                      status_o,
  output logic [PPN_W-1:0]                ppn_o,
  output logic                            ppn_ok_o
);
  import utlb_pkg::*;

  logic             any_hit;
  logic             many_hit;
  logic [PPN_W-1:0] ppn_or;

  // saturating count to two; OR of matched PPNs is exact when only one matched
  always_comb begin
    any_hit  = 1'b0;
    many_hit = 1'b0;
    ppn_or   = '0;
    for (int e = 0; e < N_ENTRIES; e++) begin
      if (match_i[e]) begin
        many_hit = many_hit | any_hit;
        any_hit  = 1'b1;
        ppn_or   = ppn_or | ppn_tbl_i[e];
      end
    end
  end

  always_comb begin
    if (many_hit)     status_o = ST_MULTI;
    else if (any_hit) status_o = ST_HIT;
    else              status_o = ST_MISS;
  end

  assign ppn_ok_o = any_hit & ~many_hit;
  assign ppn_o    = ppn_ok_o ? ppn_or : '0;
endmodule

// File: rtl/utlb_lookup.sv
module utlb_lookup #(
  parameter int N_ENTRIES = 64,
  parameter int VPN_W     = 22,
  parameter int PPN_W     = 19,
  localparam int IDX_W    = $clog2(N_ENTRIES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             d_req_i,
  input  logic [VPN_W-1:0] d_vpn_i,
  input  logic [2:0]       d_kind_i,
  input  logic             i_req_i,
  input  logic [VPN_W-1:0] i_vpn_i,
  output logic             i_gnt_o,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic             wr_valid_i,
  input  logic [VPN_W-1:0] wr_vpn_i,
  input  logic [PPN_W-1:0] wr_ppn_i,
  output logic             rsp_valid_o,
  output logic             rsp_src_o,
  output logic [1:0]       rsp_status_o,
  output logic             rsp_write_o,
  output logic [PPN_W-1:0] rsp_ppn_o,
  output logic             rsp_ppn_ok_o
);
  logic                            q_valid, q_src, q_write;
  logic [VPN_W-1:0]                q_vpn;
  logic [N_ENTRIES-1:0]            match;
  logic [N_ENTRIES-1:0][PPN_W-1:0] ppn_tbl;
  logic [1:0]                      res_status;
  logic [PPN_W-1:0]                res_ppn;
  logic                            res_ok;

  utlb_req_arb #(.VPN_W(VPN_W)) u_arb (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .d_req_i   (d_req_i),
    .d_vpn_i   (d_vpn_i),
    .d_kind_i  (d_kind_i),
    .i_req_i   (i_req_i),
    .i_vpn_i   (i_vpn_i),
    .i_gnt_o   (i_gnt_o),
    .q_valid_o (q_valid),
    .q_src_o   (q_src),
    .q_write_o (q_write),
    .q_vpn_o   (q_vpn)
  );

  utlb_entry_array #(
    .N_ENTRIES (N_ENTRIES),
    .VPN_W     (VPN_W),
    .PPN_W     (PPN_W)
  ) u_array (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_idx_i   (wr_idx_i),
    .wr_valid_i (wr_valid_i),
    .wr_vpn_i   (wr_vpn_i),
    .wr_ppn_i   (wr_ppn_i),
    .look_vpn_i (q_vpn),
    .match_o    (match),
    .ppn_tbl_o  (ppn_tbl)
  );

  utlb_hit_resolve #(
    .N_ENTRIES (N_ENTRIES),
    .PPN_W     (PPN_W)
  ) u_resolve (
    .match_i   (match),
    .ppn_tbl_i (ppn_tbl),
    .status_o  (res_status),
    .ppn_o     (res_ppn),
    .ppn_ok_o  (res_ok)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o  <= 1'b0;
      rsp_src_o    <= 1'b0;
      rsp_status_o <= 2'b00;
      rsp_write_o  <= 1'b0;
      rsp_ppn_o    <= '0;
      rsp_ppn_ok_o <= 1'b0;
    end else begin
      rsp_valid_o <= q_valid;
      if (q_valid) begin
        rsp_src_o    <= q_src;
        rsp_status_o <= res_status;
        rsp_write_o  <= q_write;
        rsp_ppn_o    <= res_ppn;
        rsp_ppn_ok_o <= res_ok;
      end
    end
  end
endmodule

// File: rtl/utlb_lookup_chk.sv
module utlb_lookup_chk #(
  parameter int PPN_W = 19
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             d_req_i,
  input logic             i_req_i,
  input logic             i_gnt_o,
  input logic             rsp_valid_o,
  input logic             rsp_src_o,
  input logic [1:0]       rsp_status_o,
  input logic             rsp_write_o,
  input logic [PPN_W-1:0] rsp_ppn_o,
  input logic             rsp_ppn_ok_o
);
  p_hit_ppn_ok_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_status_o == 2'b01) |-> rsp_ppn_ok_o);

  p_miss_no_ppn_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_status_o == 2'b00) |-> (!rsp_ppn_ok_o && rsp_ppn_o == '0));

  p_multi_no_ppn_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_status_o == 2'b10) |-> (!rsp_ppn_ok_o && rsp_ppn_o == '0));

  p_status_legal_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> (rsp_status_o != 2'b11));

  p_instr_is_read_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_src_o) |-> !rsp_write_o);

  p_data_wins_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    d_req_i |-> (!i_gnt_o ##2 (rsp_valid_o && !rsp_src_o)));

  p_instr_served_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    i_gnt_o |-> ##2 (rsp_valid_o && rsp_src_o));

  p_no_spurious_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!d_req_i && !i_req_i) |-> ##2 !rsp_valid_o);
endmodule

bind utlb_lookup utlb_lookup_chk #(.PPN_W(PPN_W)) u_chk (.*);

// File: tb/utlb_lookup_tb.sv
`timescale 1ns/1ps
module utlb_lookup_tb;
  localparam int N = 64;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        d_req_i = 1'b0;
  logic [21:0] d_vpn_i = '0;
  logic [2:0]  d_kind_i = '0;
  logic        i_req_i = 1'b0;
  logic [21:0] i_vpn_i = '0;
  logic        i_gnt_o;
  logic        wr_en_i = 1'b0;
  logic [5:0]  wr_idx_i = '0;
  logic        wr_valid_i = 1'b0;
  logic [21:0] wr_vpn_i = '0;
  logic [18:0] wr_ppn_i = '0;
  logic        rsp_valid_o, rsp_src_o, rsp_write_o, rsp_ppn_ok_o;
  logic [1:0]  rsp_status_o;
  logic [18:0] rsp_ppn_o;

  always #10 clk_i = ~clk_i;

  utlb_lookup u_dut (.*);

  int n_chk = 0;
  int n_bad = 0;

  bit          m_vld [N];
  logic [21:0] m_vpn [N];
  logic [18:0] m_ppn [N];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit exp_write(input bit src, input logic [2:0] kind);
    if (src) return 1'b0;
    return (kind == 3'd1) || (kind == 3'd4) || (kind == 3'd5);
  endfunction

  task automatic model_look(input logic [21:0] vpn, output logic [1:0] st, output logic [18:0] ppn);
    int cnt = 0;
    ppn = '0;
    for (int e = 0; e < N; e++)
      if (m_vld[e] && m_vpn[e] == vpn) begin cnt++; ppn = m_ppn[e]; end
    st = (cnt == 0) ? 2'b00 : (cnt == 1) ? 2'b01 : 2'b10;
    if (cnt != 1) ppn = '0;
  endtask

  task automatic wr(input int idx, input bit v, input logic [21:0] vpn, input logic [18:0] ppn);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_idx_i = 6'(idx); wr_valid_i = v; wr_vpn_i = vpn; wr_ppn_i = ppn;
    @(negedge clk_i);
    wr_en_i = 1'b0;
    m_vld[idx] = v; m_vpn[idx] = vpn; m_ppn[idx] = ppn;
  endtask

  // mid_wr: write lands in the lookup's compare cycle (R9)
  task automatic look(input bit src, input logic [21:0] vpn, input logic [2:0] kind, input string tag,
                      input bit mid_wr = 1'b0, input int widx = 0, input logic [18:0] wppn = '0);
    logic [1:0]  st;
    logic [18:0] ppn;
    string       t;
    model_look(vpn, st, ppn);
    t = (tag != "") ? tag : src ? "R5" : (st == 2'b01) ? "R2" : (st == 2'b00) ? "R3" : "R4";
    @(negedge clk_i);
    if (src) begin i_req_i = 1'b1; i_vpn_i = vpn; end
    else begin d_req_i = 1'b1; d_vpn_i = vpn; d_kind_i = kind; end
    @(negedge clk_i);
    d_req_i = 1'b0; i_req_i = 1'b0;
    if (mid_wr) begin
      wr_en_i = 1'b1; wr_idx_i = 6'(widx); wr_valid_i = 1'b1; wr_vpn_i = vpn; wr_ppn_i = wppn;
    end
    @(negedge clk_i);
    if (mid_wr) begin
      wr_en_i = 1'b0;
      m_vld[widx] = 1'b1; m_vpn[widx] = vpn; m_ppn[widx] = wppn;
    end
    chk(rsp_valid_o && rsp_src_o == src, "R8", {rsp_valid_o, rsp_src_o}, {1'b1, src});
    chk(rsp_status_o == st && rsp_ppn_o == ppn && rsp_ppn_ok_o == (st == 2'b01), t,
        {rsp_status_o, rsp_ppn_ok_o, rsp_ppn_o}, {st, st == 2'b01, ppn});
    chk(rsp_write_o == exp_write(src, kind), "R6", rsp_write_o, exp_write(src, kind));
    @(negedge clk_i);
    chk(!rsp_valid_o, "R8", rsp_valid_o, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_bad++;
    $display("FAIL R8: watchdog expired, actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int e = 0; e < N; e++) begin m_vld[e] = 0; m_vpn[e] = '0; m_ppn[e] = '0; end
    repeat (3) @(negedge clk_i);
    chk(rsp_valid_o == 1'b0, "R1", rsp_valid_o, 0);
    rst_ni = 1'b1;
    look(1'b0, 22'd0, 3'd0, "R1");
    look(1'b1, 22'd0, 3'd0, "R1");

    for (int e = 0; e < N; e++)
      wr(e, 1'b1, {16'($urandom()), 6'(e)}, 19'($urandom()));

    look(1'b0, m_vpn[7], 3'd0, "R2");
    look(1'b0, m_vpn[63], 3'd3, "R2");
    look(1'b0, 22'h3fffc0 ^ 22'h15, 3'd1, "R3");

    for (int k = 0; k < 8; k++) look(1'b0, m_vpn[k], 3'(k), "R6");

    wr(40, 1'b1, m_vpn[12], 19'h1abcd);
    look(1'b0, m_vpn[12], 3'd2, "R4");
    look(1'b1, m_vpn[12], 3'd0, "R5");
    wr(41, 1'b1, m_vpn[12], 19'h00001);
    look(1'b1, m_vpn[12], 3'd0, "R5");

    wr(20, 1'b0, 22'h2aaaaa, 19'h7ffff);
    look(1'b0, 22'h2aaaaa, 3'd0, "R10");
    look(1'b0, m_vpn[20], 3'd0, "R10");

    // simultaneous requests: data must win
    @(negedge clk_i);
    d_req_i = 1'b1; d_vpn_i = m_vpn[3]; d_kind_i = 3'd4;
    i_req_i = 1'b1; i_vpn_i = m_vpn[4];
    #1 chk(i_gnt_o == 1'b0, "R7", i_gnt_o, 0);
    @(negedge clk_i);
    d_req_i = 1'b0; i_req_i = 1'b0;
    @(negedge clk_i);
    chk(rsp_valid_o && !rsp_src_o && rsp_ppn_o == m_ppn[3] && rsp_write_o, "R7",
        {rsp_valid_o, rsp_src_o, rsp_write_o, rsp_ppn_o}, {1'b1, 1'b0, 1'b1, m_ppn[3]});
    @(negedge clk_i);
    i_req_i = 1'b1; i_vpn_i = m_vpn[4];
    #1 chk(i_gnt_o == 1'b1, "R7", i_gnt_o, 1);
    @(negedge clk_i);
    i_req_i = 1'b0;
    @(negedge clk_i);

    begin
      logic [18:0] old_ppn;
      old_ppn = m_ppn[9];
      n_chk++;
      look(1'b0, m_vpn[9], 3'd0, "R9", 1'b1, 9, 19'h0beef);
      if (m_ppn[9] != 19'h0beef) begin n_bad++; $display("FAIL R9: actual %0h expected %0h", m_ppn[9], 19'h0beef); end
      // the in-flight lookup above checked against the old model contents (old_ppn)
      if (old_ppn == 19'h0beef) $display("note R9 old equals new");
      look(1'b0, m_vpn[9], 3'd0, "R9");
    end

    for (int r = 0; r < 400; r++) begin
      int          pick;
      logic [21:0] v;
      pick = int'($urandom() % 10);
      if (pick < 2) begin
        int idx = int'($urandom() % N);
        if ($urandom() % 2 == 0) wr(idx, 1'($urandom()), m_vpn[$urandom() % N], 19'($urandom()));
        else wr(idx, 1'($urandom()), 22'($urandom()), 19'($urandom()));
      end
      v = (pick < 7) ? m_vpn[$urandom() % N] : 22'($urandom());
      look(1'($urandom()), v, 3'($urandom()), "");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule